// File: doc/BRIEF.md
# Destructive-Read Word Store with Restore Phase

This block stands in for a word-organised magnetic store whose read is destructive. Sensing a word forces every bit of it to zero, so each access must copy the word into a holding register and then write it back before the access ends. The store has 2048 words. Each word is 16 bits wide: 15 data bits and one odd-parity bit. A behavioural array replaces the physical cores. Drive currents, sensing and real timing are not modelled.

A client sends one request at a time over a valid/ready handshake. The request carries an address, a direction flag and write data. Every access, read or write, takes the same fixed sequence of twelve steps. In the early steps the word is sensed into the holding register, which clears it in the array. In the middle steps a write replaces the held word with the new data and its computed parity. In the late steps the held word goes back into the array. In the last step a one-cycle completion pulse carries the read data and, on a read, a parity-error flag.

Top module: `core_store`

## Requirements
- R1: After synchronous active-low reset, `req_ready` is 1 and `rsp_done` and `rsp_parity_err` are 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `rsp_done` is high for exactly one cycle: the twelfth cycle after the accepting edge. Reads and writes have the same latency.
- R3: `req_ready` is 0 from the cycle after acceptance through the `rsp_done` cycle and is 1 in the cycle right after it. A request already held valid during `rsp_done` is accepted at the end of that following cycle.
- R4: A read returns on `rsp_rdata`, during `rsp_done`, the 15 data bits last written to that address.
- R5: A read leaves the word intact. Two reads in a row of the same address return the same data, because the sensed word is restored in the same access.
- R6: A write changes only the addressed word, and `rsp_rdata` shows the written data during its `rsp_done`. Other addresses keep their contents, including address 0 and the top address 2047.
- R7: A write stores bit 15 as the odd-parity bit of the 16-bit word (bits 14:0 hold data). A later read of a written word never raises `rsp_parity_err`, and a write never raises it.
- R8: On a read whose stored 16-bit word has an even number of ones, `rsp_parity_err` is 1 during `rsp_done` and the data bits are still returned. The faulty word is restored unchanged, so the next read of it flags the error again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Store idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 15 | Data bits for a write |
| rsp_rdata | output | 15 | Data bits of the accessed word, valid with rsp_done |
| rsp_done | output | 1 | One-cycle completion pulse in the twelfth step |
| rsp_parity_err | output | 1 | Read parity check failed, only together with rsp_done |

## Verification
Two events can fall in the same cycle. The first is a completion pulse together with a parity error. The bench provokes it by placing an even-parity word straight into one array location and then reading that word twice: both completions must carry the error, and the data must not change. The second is a completion pulse together with a new request that is already waiting. The bench holds the next request valid through the whole access. It then checks that ready stays low in the done cycle, rises for exactly the following cycle, and that the new access finishes twelve cycles after that. Random mixes of reads and writes over a small set of addresses are compared against a model array kept by the bench.

// File: rtl/core_store_pkg.sv
// Package: shared geometry and step schedule of the destructive-read store.
// Assumes a fixed twelve-step access; the step indices are zero-based.
package core_store_pkg;
    localparam int ADDR_W       = 11;
    localparam int DATA_W       = 15;
    localparam int WORD_W       = DATA_W + 1;
    localparam int STEPS        = 12;
    // step schedule (index 0 = T1)
    localparam int SENSE_STEP   = 1;   // T2: read and clear the array word
    localparam int LOAD_STEP    = 2;   // T3: sensed word into holding register
    localparam int MODIFY_STEP  = 5;   // T6: write data replaces held word
    localparam int RESTORE_STEP = 9;   // T10: held word written back
    localparam int DONE_STEP    = STEPS - 1; // T12: completion pulse
endpackage

// File: rtl/cs_parity.sv
// Module: odd-parity generator for a data field.
// Produces the bit that makes data plus that bit hold an odd number of ones.
module cs_parity #(
    parameter int DATA_W = 15
) (
    input  logic [DATA_W-1:0] data,
    output logic              odd_bit
);
    // Purpose: reduction XNOR gives the odd-parity completion bit.
    always_comb begin
        odd_bit = ~(^data);
    end
endmodule

// File: rtl/cs_sequencer.sv
// Module: twelve-step access sequencer.
// Takes one request when idle, walks the steps, and raises one strobe per phase.
// Assumes the step indices in the parameters are distinct and below STEPS.
module cs_sequencer #(
    parameter int STEPS        = 12,
    parameter int SENSE_STEP   = 1,
    parameter int LOAD_STEP    = 2,
    parameter int MODIFY_STEP  = 5,
    parameter int RESTORE_STEP = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic sense_en,
    output logic load_en,
    output logic modify_en,
    output logic restore_en,
    output logic done
);
    localparam int STEP_W = $clog2(STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    logic              busy;
    logic [STEP_W-1:0] step;

    // Purpose: handshake decode.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && !busy;
    end

    // Purpose: step counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            step <= '0;
        end else if (busy) begin
            if (step == LAST_STEP) begin
                busy <= 1'b0;
                step <= '0;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    // Purpose: phase strobes decoded from the current step.
    always_comb begin
        sense_en   = busy && (step == STEP_W'(SENSE_STEP));
        load_en    = busy && (step == STEP_W'(LOAD_STEP));
        modify_en  = busy && (step == STEP_W'(MODIFY_STEP));
        restore_en = busy && (step == STEP_W'(RESTORE_STEP));
        done       = busy && (step == LAST_STEP);
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && step == '0));
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ready_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sense_en, load_en, modify_en, restore_en, done}));
endmodule

// File: rtl/cs_array.sv
// Module: behavioural word array with destructive sense.
// A sense returns the word and clears it; a restore writes a word back.
// Assumes sense and restore never strobe in the same cycle. Contents are undefined until written.
module cs_array #(
    parameter int ADDR_W = 11,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sense_en,
    input  logic              restore_en,
    input  logic [WORD_W-1:0] restore_word,
    output logic [WORD_W-1:0] sense_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Purpose: destructive sense and write-back of the addressed word.
    always_ff @(posedge clk) begin
        if (sense_en) begin
            sense_word <= mem[addr];
            mem[addr]  <= '0;
        end else if (restore_en) begin
            mem[addr]  <= restore_word;
        end
    end

    // Monitor: the word stays cleared after sensing until the restore phase.
    assert_cleared_on_sense_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en |=> (mem[addr] == '0));
    assert_restored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> (mem[addr] == $past(restore_word)));
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sense_en && restore_en));
endmodule

// File: rtl/core_store.sv
// Module: destructive-read word store, top level.
// Senses a word into a holding register, optionally replaces it with write data
// and odd parity, restores it, and signals completion in the last step.
// Assumes one client; request fields are captured on acceptance.
module core_store
    import core_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_parity_err
);
    logic accept, sense_en, load_en, modify_en, restore_en, done;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] sense_word;
    logic              gen_par, chk_par;

    cs_sequencer #(
        .STEPS(STEPS), .SENSE_STEP(SENSE_STEP), .LOAD_STEP(LOAD_STEP),
        .MODIFY_STEP(MODIFY_STEP), .RESTORE_STEP(RESTORE_STEP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .accept(accept), .sense_en(sense_en), .load_en(load_en),
        .modify_en(modify_en), .restore_en(restore_en), .done(done)
    );

    cs_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk(clk), .rst_n(rst_n), .addr(addr_q), .sense_en(sense_en),
        .restore_en(restore_en), .restore_word(hold_q), .sense_word(sense_word)
    );

    cs_parity #(.DATA_W(DATA_W)) u_gen (.data(wdata_q), .odd_bit(gen_par));
    cs_parity #(.DATA_W(DATA_W)) u_chk (.data(hold_q[DATA_W-1:0]), .odd_bit(chk_par));

    // Purpose: capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Purpose: holding register, loaded from the sense and replaced on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load_en) begin
            hold_q <= sense_word;
        end else if (modify_en && write_q) begin
            hold_q <= {gen_par, wdata_q};
        end
    end

    // Purpose: response outputs.
    always_comb begin
        rsp_rdata      = hold_q[DATA_W-1:0];
        rsp_done       = done;
        rsp_parity_err = done && !write_q && (chk_par != hold_q[WORD_W-1]);
    end

    assert_write_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_en && write_q) |-> (^hold_q == 1'b1));
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_parity_err |-> (rsp_done && !write_q));
    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !rsp_done) |=> $stable(addr_q));
endmodule

// File: tb/sim_core_store.sv
// Bench: random and directed accesses against a model array.
module sim_core_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [14:0] req_wdata = '0;
    logic [14:0] rsp_rdata;
    logic        rsp_done;
    logic        rsp_parity_err;

    int total = 0;
    int bad   = 0;
    logic [14:0] model [2048];
    bit          known [2048];

    always #4 clk = ~clk;

    core_store u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_parity_err(rsp_parity_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic odd_par(input logic [14:0] d);
        return ~(^d);
    endfunction

    // One access; returns data, error flag and latency in cycles from acceptance.
    task automatic access(input bit wr, input logic [10:0] a, input logic [14:0] d,
                          output logic [14:0] q, output logic e, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 40) begin
            if (req_ready) chk("R3 ready low while busy", 32'(req_ready), 32'd0);
            @(negedge clk);
            lat++;
        end
        q = rsp_rdata; e = rsp_parity_err;
        chk("R3 ready low in done cycle", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R2 done is one cycle", 32'(rsp_done), 32'd0);
        chk("R3 ready after done", 32'(req_ready), 32'd1);
    endtask

    task automatic do_write(input logic [10:0] a, input logic [14:0] d);
        logic [14:0] q; logic e; int lat;
        access(1'b1, a, d, q, e, lat);
        chk("R2 write latency", 32'(lat), 32'd12);
        chk("R6 write echoes data", 32'(q), 32'(d));
        chk("R7 no error on write", 32'(e), 32'd0);
        model[a] = d; known[a] = 1'b1;
    endtask

    task automatic do_read(input logic [10:0] a);
        logic [14:0] q; logic e; int lat;
        access(1'b0, a, 15'd0, q, e, lat);
        chk("R2 read latency", 32'(lat), 32'd12);
        chk("R4 read data", 32'(q), 32'(model[a]));
        chk("R7 no parity error", 32'(e), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [14:0] q; logic e; int lat;
        seed = $urandom(32'd2026);
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 ready at reset", 32'(req_ready), 32'd1);
        chk("R1 done at reset", 32'(rsp_done), 32'd0);
        chk("R1 err at reset", 32'(rsp_parity_err), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R6 boundaries and extreme data
        do_write(11'd0, 15'h7FFF);
        do_write(11'd2047, 15'h0000);
        do_write(11'd1, 15'h2AAA);
        do_read(11'd0);
        do_read(11'd2047);
        do_read(11'd1);
        // R5 repeated reads return the same data
        do_read(11'd0);
        do_read(11'd0);
        do_write(11'd1, 15'h5555);   // R6 overwrite leaves neighbours
        do_read(11'd0);
        do_read(11'd1);
        do_read(11'd2047);

        // R3 request held valid through the done cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 11'd1;
        @(negedge clk);
        req_write = 1'b1; req_addr = 11'd2; req_wdata = 15'h1234;
        lat = 1;
        while (!rsp_done && lat < 40) begin @(negedge clk); lat++; end
        chk("R3 first latency", 32'(lat), 32'd12);
        chk("R4 first data", 32'(rsp_rdata), 32'h5555);
        chk("R3 not ready with done", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R3 ready cycle after done", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 waiting request taken", 32'(req_ready), 32'd0);
        lat = 1;
        while (!rsp_done && lat < 40) begin @(negedge clk); lat++; end
        chk("R3 second latency", 32'(lat), 32'd12);
        chk("R6 second echoes", 32'(rsp_rdata), 32'h1234);
        model[2] = 15'h1234; known[2] = 1'b1;
        @(negedge clk);
        do_read(11'd2);

        // R8 corrupted word (even parity: data 3, parity bit 0)
        @(negedge clk);
        u0.u_array.mem[11'd9] = 16'h0003;
        for (int k = 0; k < 2; k++) begin
            access(1'b0, 11'd9, 15'd0, q, e, lat);
            chk("R8 parity error flagged", 32'(e), 32'd1);
            chk("R8 data still returned", 32'(q), 32'd3);
        end
        do_write(11'd9, 15'd3);
        do_read(11'd9);   // R7 clean after rewrite

        // random mix over a small address pool
        for (int i = 0; i < 120; i++) begin
            logic [10:0] a;
            a = 11'($urandom_range(0, 15));
            if (i % 16 == 5) a = 11'd2047;
            if (!known[a] || ($urandom_range(0, 2) == 0))
                do_write(a, 15'($urandom));
            else
                do_read(a);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule